// File: doc/BRIEF.md
# High-Voltage Programming Entry Sequencer

This block sits on the host side of a programming fixture. It moves a target device into its high-voltage parallel programming mode through a fixed order of steps. It drives three things: a supply-enable line for the target's supply, a high-voltage-enable line that lifts the target's reset pin to the programming voltage, and a 4-bit select pattern on the target's mode pins. Every delay is counted in clock cycles. The count comes from a cycles-per-microsecond parameter, so a single setting moves every window together.

A one-cycle start pulse begins a sequence. A flow-select input, sampled only with that pulse, picks one of two flows. The timed flow raises high voltage a fixed delay after the supply comes on. The comparator flow raises high voltage one cycle after an external supply-threshold input reports that the supply has crossed roughly 1 V. If that input stays low past a bounded wait, the sequence is aborted with an error. Once high voltage is on, the mode pattern is held frozen for a guard window. Ready is then raised at a later fixed point, and the block waits for an exit request. Any exit drops every output and enforces a minimum off time before another start is taken.

Top module: `hv_entry_seq`

## Requirements
- R1: Out of reset, supply_en_o, hv_en_o, ready_o and timeout_o are 0, pat_hold_o is 0 and pat_o is 4'b0000.
- R2: In the timed flow (flow_sel_i = 0 with the start pulse), supply_en_o rises in the cycle after start is sampled, and hv_en_o rises exactly HV_DLY_CYC cycles after supply_en_o. HV_DLY_CYC defaults to 40 us and must lie within 20 to 60 us. hv_en_o is never high while supply_en_o is low.
- R3: pat_o stays at 4'b0000, and pat_hold_o stays high, from the start until HOLD_CYC (10 us) cycles after hv_en_o rises. In that cycle pat_hold_o falls.
- R4: ready_o rises exactly READY_CYC (300 us) cycles after hv_en_o rises. It stays high, together with hv_en_o, until an exit.
- R5: In the comparator flow (flow_sel_i = 1), hv_en_o rises in the cycle after vth_ok_i is sampled high while the block waits for the threshold. A high sample in the last cycle of the wait still counts.
- R6: In the comparator flow, if vth_ok_i is not sampled high within TO_CYC cycles of the supply turning on, supply_en_o and hv_en_o are 0 from the next cycle. timeout_o is 1 from then until the next accepted start clears it.
- R7: exit_i sampled high in any active step (ramp, threshold wait, hold, settle or ready) turns off supply_en_o, hv_en_o, ready_o and pat_hold_o in the next cycle.
- R8: After any exit or timeout, every output stays off, and start is ignored, for OFF_CYC cycles. A start sampled OFF_CYC+1 cycles after the shutdown edge is accepted.
- R9: start_i and flow_sel_i are ignored while a sequence is active. The flow and the timing of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| flow_sel_i | input | 1 | 0 = timed flow, 1 = comparator flow; sampled with start |
| vth_ok_i | input | 1 | Supply-threshold comparator result |
| exit_i | input | 1 | Leave programming mode / abort |
| supply_en_o | output | 1 | Target supply enable |
| hv_en_o | output | 1 | High voltage on target reset pin |
| pat_o | output | 4 | Mode-select pattern on target enable pins |
| pat_hold_o | output | 1 | Mode pins must not be changed by command logic |
| ready_o | output | 1 | Target may now receive programming commands |
| timeout_o | output | 1 | Threshold wait expired; cleared by next accepted start |

## Verification
The timed flow is run undisturbed, run with a stray start of the other flow injected during the ramp, and run aborted during the ramp. The undisturbed run pins the high-voltage, hold-release and ready edges to the exact cycle, one cycle on either side. The other two runs show that mid-sequence inputs are ignored and that an exit cuts the outputs at once. The comparator flow is swept over threshold arrival delays from zero to the last permitted cycle, and then given no threshold at all. This separates an off-by-one in the wait bound from a true timeout. Restarts are placed one cycle inside and exactly at the end of the off window, which exposes a miscounted off time.

// File: rtl/hv_entry_seq.sv
module hv_entry_seq #(
  parameter int CYC_PER_US = 16,
  parameter int HV_DLY_CYC = 40 * CYC_PER_US,
  parameter int HOLD_US    = 10,
  parameter int READY_US   = 300,
  parameter int TIMEOUT_US = 100,
  parameter int OFF_US     = 50,
  parameter logic [3:0] ENTRY_PAT = 4'b0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       flow_sel_i,
  input  logic       vth_ok_i,
  input  logic       exit_i,
  output logic       supply_en_o,
  output logic       hv_en_o,
  output logic [3:0] pat_o,
  output logic       pat_hold_o,
  output logic       ready_o,
  output logic       timeout_o
);

  localparam int HOLD_CYC  = HOLD_US * CYC_PER_US;
  localparam int READY_CYC = READY_US * CYC_PER_US;
  localparam int TO_CYC    = TIMEOUT_US * CYC_PER_US;
  localparam int OFF_CYC   = OFF_US * CYC_PER_US;
  localparam int MAX_A     = (HV_DLY_CYC > READY_CYC) ? HV_DLY_CYC : READY_CYC;
  localparam int MAX_B     = (TO_CYC > OFF_CYC) ? TO_CYC : OFF_CYC;
  localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW        = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RAMP, S_WAITV, S_HOLD, S_SETTLE, S_READY, S_OFF
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          flow_q;
  logic          active;

  assign active      = (st != S_IDLE) && (st != S_OFF);
  assign supply_en_o = active;
  assign hv_en_o     = (st == S_HOLD) || (st == S_SETTLE) || (st == S_READY);
  assign pat_hold_o  = (st == S_RAMP) || (st == S_WAITV) || (st == S_HOLD);
  assign ready_o     = (st == S_READY);
  assign pat_o       = ENTRY_PAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      flow_q    <= 1'b0;
      timeout_o <= 1'b0;
    end else if (active && exit_i) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st        <= flow_sel_i ? S_WAITV : S_RAMP;
          flow_q    <= flow_sel_i;
          timeout_o <= 1'b0;
          cnt       <= '0;
        end
        S_RAMP: if (cnt == CW'(HV_DLY_CYC - 1)) begin
          st  <= S_HOLD;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_WAITV: if (vth_ok_i) begin
          st  <= S_HOLD;
          cnt <= '0;
        end else if (cnt == CW'(TO_CYC - 1)) begin
          st        <= S_OFF;
          timeout_o <= 1'b1;
          cnt       <= '0;
        end else cnt <= cnt + 1'b1;
        S_HOLD: begin
          if (cnt == CW'(HOLD_CYC - 1)) st <= S_SETTLE;
          cnt <= cnt + 1'b1;
        end
        S_SETTLE: begin
          if (cnt == CW'(READY_CYC - 1)) st <= S_READY;
          cnt <= cnt + 1'b1;
        end
        S_READY: cnt <= cnt;
        S_OFF: if (cnt == CW'(OFF_CYC - 1)) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  initial begin
    // R2
    hv_dly_window_chk: assert (HV_DLY_CYC >= 20 * CYC_PER_US && HV_DLY_CYC <= 60 * CYC_PER_US);
  end

  // R2
  hv_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en_o |-> supply_en_o);

  // R4
  ready_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (hv_en_o && !pat_hold_o));

  // R5
  cmp_hv_on_vth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hv_en_o) && flow_q) |-> $past(vth_ok_i));

  // R6
  timeout_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!supply_en_o && !hv_en_o));

  // R7
  exit_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_en_o && exit_i) |=> (!supply_en_o && !hv_en_o && !ready_o));

  // R8
  off_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en_o) |=> !supply_en_o);

endmodule

// File: tb/sim_hv_entry_seq.sv
module sim_hv_entry_seq;
  localparam int CPU   = 2;
  localparam int DLY   = 40 * CPU;
  localparam int HOLD  = 10 * CPU;
  localparam int READY = 300 * CPU;
  localparam int TO    = 50 * CPU;
  localparam int OFF   = 20 * CPU;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, flow_sel_i = 0, vth_ok_i = 0, exit_i = 0;
  logic supply_en_o, hv_en_o, pat_hold_o, ready_o, timeout_o;
  logic [3:0] pat_o;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  hv_entry_seq #(.CYC_PER_US(CPU), .TIMEOUT_US(50), .OFF_US(20)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .flow_sel_i(flow_sel_i),
    .vth_ok_i(vth_ok_i), .exit_i(exit_i), .supply_en_o(supply_en_o),
    .hv_en_o(hv_en_o), .pat_o(pat_o), .pat_hold_o(pat_hold_o),
    .ready_o(ready_o), .timeout_o(timeout_o));

  // outputs packed as {supply, hv, hold, ready, timeout}
  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {supply_en_o, hv_en_o, pat_hold_o, ready_o, timeout_o};
    n_run++;
    if (act !== exp || pat_o !== 4'b0000) begin
      n_fail++;
      $display("FAIL %s: outs=%b pat=%b expected outs=%b pat=0000", req, act, pat_o, exp);
    end
  endtask

  task automatic adv(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start(logic f);
    start_i = 1; flow_sel_i = f;
    adv(1);
    start_i = 0; flow_sel_i = 0;
  endtask

  task automatic do_exit;
    exit_i = 1;
    adv(1);
    exit_i = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: outs=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int vd[5];
    vd = '{0, 1, 7, 50, TO - 1};
    adv(3);
    chk("R1 reset", 5'b00000);
    rst_n = 1;
    adv(2);
    chk("R1 after reset", 5'b00000);

    // timed flow, full sequence
    pulse_start(0);
    chk("R2 supply on", 5'b10100);
    adv(DLY - 1);
    chk("R2 hv not yet", 5'b10100);
    adv(1);
    chk("R2 hv on", 5'b11100);
    adv(HOLD - 1);
    chk("R3 hold end-1", 5'b11100);
    adv(1);
    chk("R3 hold released", 5'b11000);
    adv(READY - HOLD - 1);
    chk("R4 ready not yet", 5'b11000);
    adv(1);
    chk("R4 ready", 5'b11010);
    adv(25);
    chk("R4 ready held", 5'b11010);
    do_exit();
    chk("R7 exit from ready", 5'b00000);

    // off window: start one cycle early is ignored
    adv(OFF - 1);
    start_i = 1; adv(1); start_i = 0;
    adv(2);
    chk("R8 start in off ignored", 5'b00000);
    pulse_start(0);
    chk("R8 restart after off", 5'b10100);
    do_exit();
    chk("R7 exit from ramp", 5'b00000);
    adv(OFF);
    start_i = 1; adv(1); start_i = 0;
    chk("R8 start at off boundary", 5'b10100);
    do_exit();
    adv(OFF + 1);

    // busy start with other flow ignored
    pulse_start(0);
    adv(9);
    start_i = 1; flow_sel_i = 1; adv(1); start_i = 0; flow_sel_i = 0;
    adv(DLY - 11);
    chk("R9 hv not yet after stray start", 5'b10100);
    adv(1);
    chk("R9 hv timing unchanged", 5'b11100);
    do_exit();
    adv(OFF + 1);

    // comparator flow sweep
    foreach (vd[i]) begin
      pulse_start(1);
      if (vd[i] > 0) adv(vd[i]);
      chk($sformatf("R5 wait d=%0d", vd[i]), 5'b10100);
      vth_ok_i = 1;
      adv(1);
      vth_ok_i = 0;
      chk($sformatf("R5 hv after vth d=%0d", vd[i]), 5'b11100);
      adv(HOLD);
      chk($sformatf("R3 cmp hold released d=%0d", vd[i]), 5'b11000);
      do_exit();
      chk("R7 exit from settle", 5'b00000);
      adv(OFF + 1);
    end

    // comparator timeout
    pulse_start(1);
    adv(TO - 1);
    chk("R6 last wait cycle", 5'b10100);
    adv(1);
    chk("R6 timeout", 5'b00001);
    adv(OFF + 5);
    chk("R6 timeout sticky", 5'b00001);
    pulse_start(0);
    chk("R6 cleared by start", 5'b10100);
    do_exit();
    adv(OFF + 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule